// File: doc/BRIEF.md
# Linear Chi-Square Track Fit Engine

The engine takes one road at a time. A road is a sector number plus a short list of hit coordinates for each of eight detector layers. It steps through every way of picking one hit per layer. For each pick it forms a chi-square: each of K linear constraint terms is squared and the squares are summed. Every term is a signed dot product of the layer coordinates with a constant row, plus an offset. The constant row is chosen by the sector and by which layer, if any, is left out. A pick whose chi-square is under a programmable cut is emitted as a track.

When exactly one layer of the road has no hits, every pick is fitted in majority mode. That mode uses a reduced constant row in which the missing layer's best-fit coordinate has already been folded into the other coefficients, so no division is needed. When a full eight-layer pick fails the cut but stays under a second, looser threshold, it is refitted eight times, leaving out one layer each time. The best refit that passes the cut is emitted. A testbench or host loads the constants through a write-only memory port before any roads are sent.

Top module: `tf_fit_engine`

## Requirements
- R1: After reset, `busy_o`, `road_done_o` and `trk_valid_o` are all low.
- R2: The constant word at linear address ((sector*9 + variant)*K + k)*9 + j is coefficient j of term k for j<8, and the term offset for j=8. Variant 0 is the full fit and variant 1+l is the reduced row used when layer l is absent. The chi-square is the sum over k of (offset + sum of coef*x over the layers present)^2, computed in signed integers.
- R3: Every combination of one hit per layer is fitted exactly once. Combinations are taken in odometer order with layer 0 stepping fastest. `trk_idx_o` bits [2l+1:2l] hold the hit index used in layer l.
- R4: A full combination is emitted exactly when its chi-square is strictly below the cut, with mode 0 and miss mask 0.
- R5: If exactly one layer l has a hit count of 0, each combination of the other layers is fitted with variant 1+l. It is emitted when its chi-square is below the cut, with mode 1, miss mask bit l set and index 0 for layer l. No recovery refit is made in this mode.
- R6: A road with two or more empty layers produces no track and still ends with a done pulse.
- R7: A full combination with cut <= chi < high is refitted with layer d dropped (variant 1+d) for d = 0..7. Of the refits below the cut, the one with the lowest chi-square is emitted with mode 2 and miss mask bit d set. On a tie the lower layer wins. If no refit passes, or if chi >= high, nothing is emitted.
- R8: `busy_o` is high from the cycle after a start is accepted until `road_done_o`, which is a one-cycle pulse that follows the road's last track. A start while busy is ignored.
- R9: The sector, counts, hits and both thresholds are captured when a start is accepted. Later changes at those inputs do not affect the road.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Constant write strobe |
| cfg_addr_i | input | AW (10) | Constant linear address |
| cfg_data_i | input | CW (10) | Signed constant word |
| cut_i | input | CHW (53) | Acceptance threshold |
| high_i | input | CHW (53) | Recovery window upper threshold |
| road_start_i | input | 1 | Start a road |
| road_sector_i | input | SW (1) | Sector of the road |
| road_cnt_i | input | NL*CNTW (24) | Hit count per layer, 3 bits per layer |
| road_hits_i | input | NL*MAXH*CW (320) | Coordinates; hit h of layer l at bits [(l*4+h)*10 +: 10] |
| busy_o | output | 1 | Road in progress |
| road_done_o | output | 1 | Road finished, one cycle |
| trk_valid_o | output | 1 | Track output valid, one cycle per track |
| trk_mode_o | output | 2 | 0 full, 1 majority, 2 recovery |
| trk_chi_o | output | CHW (53) | Track chi-square |
| trk_idx_o | output | NL*IDXW (16) | Hit index per layer |
| trk_miss_o | output | NL (8) | Missing or dropped layer mask |

## Verification
A stuck or skipped odometer digit shows up at the ports as a wrong track count or a wrong index order within the same road, and the road ends early or late. A wrong sector or variant selection gives a chi-square that differs from the bench's own sum of squares on the very first emitted track. A recovery search that keeps the wrong best refit, or that keeps going past layer seven, gives the wrong miss mask or chi-square on the track emitted right after the eight refit cycles. Because the inputs are captured at the start, disturbing them after the start shows any capture error in the same road's results.

// File: rtl/tf_pkg.sv
package tf_pkg;
  typedef enum logic [1:0] {
    MODE_FULL = 2'd0,
    MODE_MAJ  = 2'd1,
    MODE_REC  = 2'd2
  } fit_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FIT  = 2'd1,
    ST_REC  = 2'd2,
    ST_DONE = 2'd3
  } fit_state_e;
endpackage

// File: rtl/tf_const_store.sv
module tf_const_store #(
  parameter int NL = 8,
  parameter int K  = 4,
  parameter int CW = 10,
  parameter int NS = 2,
  localparam int NJ = NL + 1,
  localparam int NV = NL + 1,
  localparam int DEPTH = NS * NV * K * NJ,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = (NS > 1) ? $clog2(NS) : 1,
  localparam int VW = $clog2(NV)
) (
  input  logic                 clk_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        waddr_i,
  input  logic [CW-1:0]        wdata_i,
  input  logic [SW-1:0]        sector_i,
  input  logic [VW-1:0]        variant_i,
  output logic [K*NJ*CW-1:0]   row_o
);
  logic [CW-1:0] mem [DEPTH];
  logic [AW-1:0] base;

  always_ff @(posedge clk_i) begin
    if (we_i && (int'(waddr_i) < DEPTH)) mem[waddr_i] <= wdata_i;
  end

  assign base = AW'((int'(sector_i) * NV + int'(variant_i)) * K * NJ);

  for (genvar k = 0; k < K; k++) begin : g_term
    for (genvar j = 0; j < NJ; j++) begin : g_word
      assign row_o[(k*NJ+j)*CW +: CW] = mem[base + AW'(k*NJ + j)];
    end
  end
endmodule

// File: rtl/tf_chi_calc.sv
module tf_chi_calc #(
  parameter int NL  = 8,
  parameter int K   = 4,
  parameter int CW  = 10,
  parameter int TW  = 25,
  parameter int CHW = 53,
  localparam int NJ = NL + 1
) (
  input  logic [NL*CW-1:0]     coord_i,
  input  logic [NL-1:0]        drop_i,
  input  logic [K*NJ*CW-1:0]   row_i,
  output logic [CHW-1:0]       chi_o
);
  always_comb begin
    logic signed [TW-1:0]   acc;
    logic signed [TW-1:0]   cs;
    logic signed [TW-1:0]   xs;
    logic signed [2*TW-1:0] a2;
    chi_o = '0;
    for (int k = 0; k < K; k++) begin
      acc = TW'($signed(row_i[(k*NJ+NL)*CW +: CW]));
      for (int j = 0; j < NL; j++) begin
        cs = TW'($signed(row_i[(k*NJ+j)*CW +: CW]));
        xs = TW'($signed(coord_i[j*CW +: CW]));
        // absent layer contributes through the reduced row only
        if (!drop_i[j]) acc = acc + cs * xs;
      end
      a2 = (2*TW)'(acc);
      chi_o = chi_o + CHW'($unsigned(a2 * a2));
    end
  end
endmodule

// File: rtl/tf_odometer.sv
module tf_odometer #(
  parameter int NL   = 8,
  parameter int MAXH = 4,
  parameter int CNTW = 3,
  parameter int IDXW = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [NL*CNTW-1:0]   cnt_i,
  input  logic                 inc_i,
  output logic [NL*IDXW-1:0]   idx_o,
  output logic                 last_o
);
  logic [NL-1:0] carry;
  logic [NL-1:0] wrap;

  assign carry[0] = inc_i;
  assign last_o   = &wrap;

  for (genvar l = 0; l < NL; l++) begin : g_digit
    logic [IDXW-1:0] idx_q, lim_q, lim_d;
    logic [CNTW-1:0] c;

    assign c = cnt_i[l*CNTW +: CNTW];
    assign lim_d = (c == '0) ? '0 :
                   (int'(c) > MAXH) ? IDXW'(MAXH - 1) : IDXW'(c - 1'b1);
    assign wrap[l] = (idx_q == lim_q);
    if (l < NL - 1) begin : g_carry
      assign carry[l+1] = carry[l] & wrap[l];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        idx_q <= '0;
        lim_q <= '0;
      end else if (load_i) begin
        idx_q <= '0;
        lim_q <= lim_d;
      end else if (carry[l]) begin
        idx_q <= wrap[l] ? '0 : idx_q + 1'b1;
      end
    end

    assign idx_o[l*IDXW +: IDXW] = idx_q;

    assert_idx_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idx_q <= lim_q);
  end
endmodule

// File: rtl/tf_fit_engine.sv
module tf_fit_engine
  import tf_pkg::*;
#(
  parameter int NL   = 8,
  parameter int MAXH = 4,
  parameter int CW   = 10,
  parameter int K    = 4,
  parameter int NS   = 2,
  localparam int NJ    = NL + 1,
  localparam int NV    = NL + 1,
  localparam int DEPTH = NS * NV * K * NJ,
  localparam int AW    = $clog2(DEPTH),
  localparam int SW    = (NS > 1) ? $clog2(NS) : 1,
  localparam int VW    = $clog2(NV),
  localparam int DW    = $clog2(NL),
  localparam int CNTW  = $clog2(MAXH + 1),
  localparam int IDXW  = (MAXH > 1) ? $clog2(MAXH) : 1,
  localparam int TW    = 2 * CW + $clog2(NJ) + 1,
  localparam int CHW   = 2 * TW + $clog2(K) + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [AW-1:0]           cfg_addr_i,
  input  logic [CW-1:0]           cfg_data_i,
  input  logic [CHW-1:0]          cut_i,
  input  logic [CHW-1:0]          high_i,
  input  logic                    road_start_i,
  input  logic [SW-1:0]           road_sector_i,
  input  logic [NL*CNTW-1:0]      road_cnt_i,
  input  logic [NL*MAXH*CW-1:0]   road_hits_i,
  output logic                    busy_o,
  output logic                    road_done_o,
  output logic                    trk_valid_o,
  output logic [1:0]              trk_mode_o,
  output logic [CHW-1:0]          trk_chi_o,
  output logic [NL*IDXW-1:0]      trk_idx_o,
  output logic [NL-1:0]           trk_miss_o
);
  fit_state_e state_q, state_d;

  logic [SW-1:0]          sector_q;
  logic [NL*MAXH*CW-1:0]  hits_q;
  logic [CHW-1:0]         cut_q, high_q;
  logic [NL-1:0]          miss_q;
  logic [DW-1:0]          drop_q;
  logic                   best_v_q;
  logic [CHW-1:0]         best_chi_q;
  logic [DW-1:0]          best_drop_q;

  logic [NL-1:0]          empty;
  logic                   start_ok;
  logic [NL*IDXW-1:0]     idx;
  logic                   last;
  logic [NL*CW-1:0]       coord;
  logic [VW-1:0]          variant, miss_var;
  logic [NL-1:0]          drop_mask;
  logic [K*NJ*CW-1:0]     row;
  logic [CHW-1:0]         chi;

  logic                   pass, win, better, adv, go_rec, emit;
  fit_mode_e              e_mode;
  logic [CHW-1:0]         e_chi;
  logic [NL-1:0]          e_miss;

  logic                   out_v_q;
  fit_mode_e              out_mode_q;
  logic [CHW-1:0]         out_chi_q;
  logic [NL*IDXW-1:0]     out_idx_q;
  logic [NL-1:0]          out_miss_q;

  // road capture
  always_comb begin
    for (int l = 0; l < NL; l++) empty[l] = (road_cnt_i[l*CNTW +: CNTW] == '0);
  end
  assign start_ok = (state_q == ST_IDLE) && road_start_i;

  tf_odometer #(.NL(NL), .MAXH(MAXH), .CNTW(CNTW), .IDXW(IDXW)) u_odo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_ok),
    .cnt_i  (road_cnt_i),
    .inc_i  (adv && !last),
    .idx_o  (idx),
    .last_o (last)
  );

  // operand select
  always_comb begin
    for (int l = 0; l < NL; l++)
      coord[l*CW +: CW] = hits_q[(l*MAXH + int'(idx[l*IDXW +: IDXW]))*CW +: CW];
    miss_var = '0;
    for (int l = 0; l < NL; l++)
      if (miss_q[l]) miss_var = VW'(l + 1);
    if (state_q == ST_REC) begin
      variant   = VW'(drop_q) + 1'b1;
      drop_mask = NL'(1) << drop_q;
    end else begin
      variant   = miss_var;
      drop_mask = miss_q;
    end
  end

  tf_const_store #(.NL(NL), .K(K), .CW(CW), .NS(NS)) u_const (
    .clk_i     (clk_i),
    .we_i      (cfg_we_i),
    .waddr_i   (cfg_addr_i),
    .wdata_i   (cfg_data_i),
    .sector_i  (sector_q),
    .variant_i (variant),
    .row_o     (row)
  );

  tf_chi_calc #(.NL(NL), .K(K), .CW(CW), .TW(TW), .CHW(CHW)) u_chi (
    .coord_i (coord),
    .drop_i  (drop_mask),
    .row_i   (row),
    .chi_o   (chi)
  );

  // fit decisions
  always_comb begin
    pass    = chi < cut_q;
    win     = chi < high_q;
    better  = pass && (!best_v_q || chi < best_chi_q);
    state_d = state_q;
    adv     = 1'b0;
    go_rec  = 1'b0;
    emit    = 1'b0;
    e_mode  = MODE_FULL;
    e_chi   = chi;
    e_miss  = drop_mask;
    unique case (state_q)
      ST_IDLE: if (road_start_i) state_d = ($countones(empty) > 1) ? ST_DONE : ST_FIT;
      ST_FIT: begin
        if (|miss_q) begin
          emit   = pass;
          e_mode = MODE_MAJ;
          adv    = 1'b1;
        end else if (pass) begin
          emit = 1'b1;
          adv  = 1'b1;
        end else if (win) begin
          go_rec  = 1'b1;
          state_d = ST_REC;
        end else begin
          adv = 1'b1;
        end
      end
      ST_REC: begin
        if (drop_q == DW'(NL - 1)) begin
          adv    = 1'b1;
          emit   = best_v_q || better;
          e_mode = MODE_REC;
          if (!better) begin
            e_chi  = best_chi_q;
            e_miss = NL'(1) << best_drop_q;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (adv) state_d = last ? ST_DONE : ST_FIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sector_q    <= '0;
      hits_q      <= '0;
      cut_q       <= '0;
      high_q      <= '0;
      miss_q      <= '0;
      drop_q      <= '0;
      best_v_q    <= 1'b0;
      best_chi_q  <= '0;
      best_drop_q <= '0;
    end else begin
      state_q <= state_d;
      if (start_ok) begin
        sector_q <= road_sector_i;
        hits_q   <= road_hits_i;
        cut_q    <= cut_i;
        high_q   <= high_i;
        miss_q   <= empty;
      end
      if (go_rec) begin
        drop_q   <= '0;
        best_v_q <= 1'b0;
      end else if (state_q == ST_REC) begin
        drop_q <= drop_q + 1'b1;
        if (better) begin
          best_v_q    <= 1'b1;
          best_chi_q  <= chi;
          best_drop_q <= drop_q;
        end
      end
    end
  end

  // track output register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_q    <= 1'b0;
      out_mode_q <= MODE_FULL;
      out_chi_q  <= '0;
      out_idx_q  <= '0;
      out_miss_q <= '0;
    end else begin
      out_v_q <= emit;
      if (emit) begin
        out_mode_q <= e_mode;
        out_chi_q  <= e_chi;
        out_idx_q  <= idx;
        out_miss_q <= e_miss;
      end
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign road_done_o = (state_q == ST_DONE);
  assign trk_valid_o = out_v_q;
  assign trk_mode_o  = out_mode_q;
  assign trk_chi_o   = out_chi_q;
  assign trk_idx_o   = out_idx_q;
  assign trk_miss_o  = out_miss_q;

  assert_emit_below_cut_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trk_valid_o |-> (trk_chi_o < cut_q));
  assert_full_no_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trk_valid_o && trk_mode_o == MODE_FULL) |-> (trk_miss_o == '0));
  assert_partial_one_layer_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trk_valid_o && trk_mode_o != MODE_FULL) |-> ($countones(trk_miss_o) == 1));
  assert_rec_only_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REC) |-> (miss_q == '0));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    road_done_o |=> (!road_done_o && !busy_o));
  assert_track_while_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trk_valid_o |-> busy_o);
  assert_start_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !road_done_o) |=> $stable(cut_q) && $stable(high_q) && $stable(sector_q));
endmodule

// File: tb/tf_fit_engine_bench.sv
module tf_fit_engine_bench;
  localparam int NL = 8, MAXH = 4, CW = 10, K = 4, NS = 2;
  localparam int NJ = NL + 1, NV = NL + 1;
  localparam int DEPTH = NS * NV * K * NJ;
  localparam int AW = $clog2(DEPTH);
  localparam int SW = 1;
  localparam int CNTW = $clog2(MAXH + 1);
  localparam int IDXW = $clog2(MAXH);
  localparam int TW = 2 * CW + $clog2(NJ) + 1;
  localparam int CHW = 2 * TW + $clog2(K) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_data = '0;
  logic [CHW-1:0] cut = '0, high = '0;
  logic start = 1'b0;
  logic [SW-1:0] sector = '0;
  logic [NL*CNTW-1:0] cnt = '0;
  logic [NL*MAXH*CW-1:0] hits = '0;
  logic busy, done, tv;
  logic [1:0] tmode;
  logic [CHW-1:0] tchi;
  logic [NL*IDXW-1:0] tidx;
  logic [NL-1:0] tmiss;

  always #10 clk = ~clk;

  tf_fit_engine u_tf_fit_engine (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_data_i(cfg_data), .cut_i(cut), .high_i(high), .road_start_i(start),
    .road_sector_i(sector), .road_cnt_i(cnt), .road_hits_i(hits),
    .busy_o(busy), .road_done_o(done), .trk_valid_o(tv), .trk_mode_o(tmode),
    .trk_chi_o(tchi), .trk_idx_o(tidx), .trk_miss_o(tmiss)
  );

  typedef struct { longint chi; int mode; int miss; int idx; } trk_t;
  trk_t act_q[$];
  trk_t exp_q[$];

  int checks = 0, errors = 0;
  bit finished = 0;

  longint cmem [NS][NV][K][NJ];
  int hit_b [NL][MAXH];
  int cnt_b [NL];
  int sec_b;
  longint cut_b, high_b;
  int cur_x [NL];

  always @(negedge clk) begin
    if (tv) act_q.push_back('{longint'(tchi), int'(tmode), int'(tmiss), int'(tidx)});
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr_const(int s, int v, int k, int j, int val);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = AW'(((s * NV + v) * K + k) * NJ + j);
    cfg_data = CW'(val);
    cmem[s][v][k][j] = longint'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic longint chi_ref(int v, int drop);
    longint sum = 0;
    for (int k = 0; k < K; k++) begin
      longint t = cmem[sec_b][v][k][NL];
      for (int j = 0; j < NL; j++)
        if (j != drop) t += cmem[sec_b][v][k][j] * longint'(cur_x[j]);
      sum += t * t;
    end
    return sum;
  endfunction

  task automatic build_expected();
    int nempty = 0, m = -1, prod = 1;
    exp_q.delete();
    for (int l = 0; l < NL; l++) begin
      if (cnt_b[l] == 0) begin nempty++; m = l; end
      prod *= (cnt_b[l] == 0) ? 1 : cnt_b[l];
    end
    if (nempty > 1) return;
    for (int c = 0; c < prod; c++) begin
      int rem = c, ipk = 0;
      longint ch;
      for (int l = 0; l < NL; l++) begin
        int r = (cnt_b[l] == 0) ? 1 : cnt_b[l];
        int id = rem % r;
        rem = rem / r;
        cur_x[l] = hit_b[l][id];
        ipk |= id << (l * IDXW);
      end
      if (m >= 0) begin
        ch = chi_ref(1 + m, m);
        if (ch < cut_b) exp_q.push_back('{ch, 1, 1 << m, ipk});
      end else begin
        ch = chi_ref(0, -1);
        if (ch < cut_b) exp_q.push_back('{ch, 0, 0, ipk});
        else if (ch < high_b) begin
          int bd = -1;
          longint bc = 0;
          for (int d = 0; d < NL; d++) begin
            longint cd = chi_ref(1 + d, d);
            if (cd < cut_b && (bd < 0 || cd < bc)) begin bd = d; bc = cd; end
          end
          if (bd >= 0) exp_q.push_back('{bc, 2, 1 << bd, ipk});
        end
      end
    end
  endtask

  task automatic drive_ports();
    sector = SW'(sec_b);
    cut = CHW'(cut_b);
    high = CHW'(high_b);
    for (int l = 0; l < NL; l++) begin
      cnt[l*CNTW +: CNTW] = CNTW'(cnt_b[l]);
      for (int h = 0; h < MAXH; h++) hits[(l*MAXH+h)*CW +: CW] = CW'(hit_b[l][h]);
    end
  endtask

  task automatic compare(string req);
    chk(act_q.size() == exp_q.size(), req, "track count", act_q.size(), exp_q.size());
    for (int i = 0; i < act_q.size() && i < exp_q.size(); i++) begin
      chk(act_q[i].chi == exp_q[i].chi, req, "chi", act_q[i].chi, exp_q[i].chi);
      chk(act_q[i].mode == exp_q[i].mode, req, "mode", act_q[i].mode, exp_q[i].mode);
      chk(act_q[i].miss == exp_q[i].miss, req, "miss", act_q[i].miss, exp_q[i].miss);
      chk(act_q[i].idx == exp_q[i].idx, req, "idx", act_q[i].idx, exp_q[i].idx);
    end
  endtask

  task automatic run_road(string req, bit disturb);
    int n = 0;
    build_expected();
    act_q.delete();
    @(negedge clk);
    drive_ports();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      // R9: scramble captured inputs, R8: extra start while busy
      sector = ~sector;
      cut = '0;
      high = '0;
      cnt = '0;
      hits = ~hits;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R8", "road_done seen", done, 1);
    @(negedge clk);
    compare(req);
  endtask

  task automatic set_road(int s, int seed);
    sec_b = s;
    for (int l = 0; l < NL; l++) begin
      cnt_b[l] = 1;
      for (int h = 0; h < MAXH; h++) hit_b[l][h] = ((l * 7 + h * 13 + seed) % 41) - 20;
    end
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(tv == 1'b0, "R1", "valid after reset", tv, 0);
  endtask

  task automatic t_load();
    for (int s = 0; s < NS; s++)
      for (int v = 0; v < NV; v++)
        for (int k = 0; k < K; k++)
          for (int j = 0; j < NJ; j++) begin
            int a = ((s * NV + v) * K + k) * NJ + j;
            wr_const(s, v, k, j, ((a * 37 + 11) % 17) - 8);
          end
  endtask

  task automatic t_single_full();
    set_road(0, 3);
    cut_b = 64'd1 << 45;
    high_b = cut_b;
    run_road("R2", 0);
    chk(act_q.size() == 1, "R4", "single full count", act_q.size(), 1);
    set_road(1, 9);
    run_road("R2", 0);
  endtask

  task automatic t_odometer();
    set_road(0, 5);
    cnt_b[0] = 2;
    cnt_b[3] = 3;
    cut_b = 64'd1 << 45;
    high_b = cut_b;
    run_road("R3", 0);
    chk(act_q.size() == 6, "R3", "combination count", act_q.size(), 6);
    if (act_q.size() >= 3) begin
      chk(act_q[1].idx == 1, "R3", "second idx", act_q[1].idx, 1);
      chk(act_q[2].idx == (1 << 6), "R3", "third idx", act_q[2].idx, 1 << 6);
    end
  endtask

  task automatic t_cut_edge();
    longint f;
    set_road(0, 17);
    for (int l = 0; l < NL; l++) cur_x[l] = hit_b[l][0];
    f = chi_ref(0, -1);
    cut_b = f;
    high_b = f;
    run_road("R4", 0);
    chk(act_q.size() == 0, "R4", "chi equal to cut rejected", act_q.size(), 0);
    cut_b = f + 1;
    high_b = f + 1;
    run_road("R4", 0);
    chk(act_q.size() == 1, "R4", "chi one below cut accepted", act_q.size(), 1);
  endtask

  task automatic t_majority();
    set_road(0, 21);
    cnt_b[5] = 0;
    cnt_b[1] = 2;
    cut_b = 64'd1 << 45;
    high_b = cut_b;
    run_road("R5", 0);
    chk(act_q.size() == 2, "R5", "majority count", act_q.size(), 2);
    if (act_q.size() > 0) chk(act_q[0].miss == 32, "R5", "majority mask", act_q[0].miss, 32);
  endtask

  task automatic t_two_empty();
    set_road(0, 2);
    cnt_b[2] = 0;
    cnt_b[6] = 0;
    cut_b = 64'd1 << 45;
    high_b = cut_b;
    run_road("R6", 0);
    chk(act_q.size() == 0, "R6", "no track with two empty layers", act_q.size(), 0);
  endtask

  task automatic t_recovery();
    for (int v = 0; v < NV; v++)
      for (int k = 0; k < K; k++)
        for (int j = 0; j < NJ; j++) begin
          int val = 0;
          if (j == NL && k == 0) val = (v == 0) ? 100 : 10 * ((v > 6) ? v - 6 : 6 - v) + 5;
          wr_const(1, v, k, j, val);
        end
    set_road(1, 4);
    cut_b = 1000;
    high_b = 20000;
    run_road("R7", 0);
    chk(act_q.size() == 1, "R7", "recovery count", act_q.size(), 1);
    if (act_q.size() == 1) begin
      chk(act_q[0].chi == 25, "R7", "recovery best chi", act_q[0].chi, 25);
      chk(act_q[0].miss == 32, "R7", "recovery dropped layer", act_q[0].miss, 32);
    end
    high_b = 10000;
    run_road("R7", 0);
    chk(act_q.size() == 0, "R7", "chi at high skips refit", act_q.size(), 0);
    wr_const(1, 3, 0, NL, 5);
    high_b = 20000;
    run_road("R7", 0);
    if (act_q.size() == 1)
      chk(act_q[0].miss == 4, "R7", "tie picks lower layer", act_q[0].miss, 4);
    else chk(0, "R7", "tie count", act_q.size(), 1);
    cut_b = 20;
    run_road("R7", 0);
    chk(act_q.size() == 0, "R7", "no refit passes", act_q.size(), 0);
  endtask

  task automatic t_capture();
    int n;
    set_road(0, 11);
    cnt_b[0] = 3;
    cnt_b[7] = 2;
    cnt_b[4] = 2;
    cut_b = 64'd1 << 45;
    high_b = cut_b;
    run_road("R9", 1);
    n = act_q.size();
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R8", "start while busy ignored", busy, 0);
    chk(act_q.size() == n, "R8", "no extra tracks", act_q.size(), n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_single_full();
    t_odometer();
    t_cut_edge();
    t_majority();
    t_two_empty();
    t_capture();
    t_recovery();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule